// File: doc/BRIEF.md
# DRAM rank power-down controller

This block sits beside the command scheduler of a DRAM controller, one instance per rank. It decides when the rank may drop into a low-power state and brings it back out. To make that decision it keeps a count of reads and writes waiting for the rank. It also counts operations still in flight: read responses, the precharge-completion window and the write-done window. It reacts to completion events by choosing between active power-down, precharge power-down and the plain active or idle states.

Wake-up is driven by an access request, or by an explicit self-refresh exit. Each wake-up raises a per-rank "earliest command cycle" value, which the scheduler compares against its own notion of time before issuing to the rank. A wake-up is never performed earlier than a fixed number of clocks after the entry that preceded it. A request that arrives too soon is held and carried out as soon as that window has passed.

All outputs are registered. A state change or strobe caused by the inputs of one cycle is visible after the next rising edge.

Top module: `rank_sleep_ctrl`

## Requirements
- R1: After reset the power state is IDLE, all counters and the earliest command cycle are zero, and no strobe is high. The state encoding on `pwr_state` is IDLE=0, REF=1, SREF=2, PRE_PDN=3, ACT=4, ACT_PDN=5.
- R2: The read count rises on `rd_enq` and falls on `rd_resp`. The write count rises on `wr_enq` and falls on `wr_issue`. Both saturate at 2^CNT_W-1 and never drop below zero.
- R3: The in-flight count rises by one for each of the following: `rd_issue`; `pre_start` when no precharge window is open; `wr_issue` when no write-done window is open. It falls on `rd_resp`, on `pre_done` of an open precharge window, and when the write-done window closes. That window closes WR_LAT cycles after the latest `wr_issue`, so a new write extends it.
- R4: The rank is ready for low power when, after this cycle's updates, the count for the direction given by `bus_is_write` is zero and the in-flight count is zero. While `ref_running` is high the in-flight count is ignored.
- R5: A `rd_resp` that leaves the rank ready moves ACT to ACT_PDN with `enter_act_pd`, or IDLE to PRE_PDN with `enter_pre_pd`.
- R6: A `pre_done` with `bank_cnt` zero moves the rank to PRE_PDN with `enter_pre_pd` if it is ready, otherwise to IDLE.
- R7: In IDLE, a nonzero `bank_cnt` moves the rank to ACT. A `sref_req` while IDLE and ready moves it to SREF with `enter_sref`.
- R8: Wake-up is allowed no earlier than the entry cycle plus TCK. A wake request that arrives sooner is held and carried out in the first allowed cycle.
- R9: An `access_req` in ACT_PDN returns the rank to ACT with `exit_act_pd`. In PRE_PDN it returns the rank to IDLE with `exit_pre_pd`. The earliest command cycle becomes the larger of its old value and the wake cycle plus TXP.
- R10: `sref_exit` in SREF returns the rank to IDLE with `exit_sref`, raising the earliest command cycle to at least the wake cycle plus TXS. An `access_req` in SREF has no effect.
- R11: The earliest command cycle never decreases, and at most one entry or exit strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_is_write | input | 1 | Current bus direction, 1 = write |
| ref_running | input | 1 | A refresh is in progress on the rank |
| bank_cnt | input | BANK_W | Number of open banks |
| rd_enq | input | 1 | A read was queued for the rank |
| rd_issue | input | 1 | A read was issued, response pending |
| rd_resp | input | 1 | A read response completed |
| wr_enq | input | 1 | A write was queued for the rank |
| wr_issue | input | 1 | A write left the queue and was issued |
| pre_start | input | 1 | A precharge was scheduled |
| pre_done | input | 1 | The scheduled precharge completed |
| access_req | input | 1 | A read or write access targets the rank |
| sref_req | input | 1 | Request to enter self-refresh |
| sref_exit | input | 1 | Request to leave self-refresh |
| pwr_state | output | 3 | Current power state |
| enter_act_pd | output | 1 | Active power-down entry strobe |
| enter_pre_pd | output | 1 | Precharge power-down entry strobe |
| enter_sref | output | 1 | Self-refresh entry strobe |
| exit_act_pd | output | 1 | Active power-down exit strobe |
| exit_pre_pd | output | 1 | Precharge power-down exit strobe |
| exit_sref | output | 1 | Self-refresh exit strobe |
| earliest_cmd | output | TW | Earliest cycle a command may go to the rank |
| rd_cnt | output | CNT_W | Queued reads |
| wr_cnt | output | CNT_W | Queued writes |
| op_cnt | output | CNT_W | In-flight operations |

## Verification
The case of interest is a last read response arriving in the same cycle as a new read enqueue. The entry decision must use the post-update counts, so the rank stays in ACT instead of sleeping. The bench drives both pulses on one edge and checks that no entry strobe appears and that the state and counts remain as computed. It then repeats the response alone in write mode with reads still queued, and expects active power-down entry. A second collision is also provoked: a wake request in the cycle after entry. The bench judges it by the state staying low-power for one more cycle before waking.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_REFRESH  = 3'd1,
    PS_SELFREF  = 3'd2,
    PS_PRE_DOWN = 3'd3,
    PS_ACTIVE   = 3'd4,
    PS_ACT_DOWN = 3'd5
  } pwr_state_e;

  // Add 'up', remove 'dn', clamp into [0, top]
  function automatic int unsigned sat_step(int unsigned cur, int unsigned up,
                                           int unsigned dn, int unsigned top);
    int unsigned raised;
    raised = cur + up;
    if (raised < dn) return 0;
    raised = raised - dn;
    return (raised > top) ? top : raised;
  endfunction

  function automatic logic is_low_power(pwr_state_e s);
    return (s == PS_PRE_DOWN) || (s == PS_ACT_DOWN) || (s == PS_SELFREF);
  endfunction

endpackage

// File: rtl/rank_op_counters.sv
module rank_op_counters
  import rank_pwr_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int WR_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_enq,
  input  logic             rd_issue,
  input  logic             rd_resp,
  input  logic             wr_enq,
  input  logic             wr_issue,
  input  logic             pre_start,
  input  logic             pre_done,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [CNT_W-1:0] wr_cnt,
  output logic [CNT_W-1:0] op_cnt,
  output logic [CNT_W-1:0] rd_next,
  output logic [CNT_W-1:0] wr_next,
  output logic [CNT_W-1:0] op_next,
  output logic             wr_done_ev
);

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
  localparam int WT_W = $clog2(WR_LAT + 1);

  logic [WT_W-1:0] wr_timer;
  logic            pre_busy;
  logic            pre_new;
  logic            pre_fin;
  logic            wr_new;
  int unsigned     op_up;
  int unsigned     op_dn;

  // internal events, named for the checker
  assign wr_done_ev = (wr_timer == WT_W'(1)) && !wr_issue;
  assign wr_new     = wr_issue && (wr_timer == '0);
  assign pre_fin    = pre_done && pre_busy;
  assign pre_new    = pre_start && (!pre_busy || pre_done);

  always_comb begin
    op_up = 32'(rd_issue) + 32'(pre_new) + 32'(wr_new);
    op_dn = 32'(rd_resp) + 32'(pre_fin) + 32'(wr_done_ev);
  end

  assign rd_next = CNT_W'(sat_step(32'(rd_cnt), 32'(rd_enq), 32'(rd_resp), CNT_MAX));
  assign wr_next = CNT_W'(sat_step(32'(wr_cnt), 32'(wr_enq), 32'(wr_issue), CNT_MAX));
  assign op_next = CNT_W'(sat_step(32'(op_cnt), op_up, op_dn, CNT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      wr_cnt   <= '0;
      op_cnt   <= '0;
      wr_timer <= '0;
      pre_busy <= 1'b0;
    end else begin
      rd_cnt <= rd_next;
      wr_cnt <= wr_next;
      op_cnt <= op_next;
      if (wr_issue)             wr_timer <= WT_W'(WR_LAT);
      else if (wr_timer != '0)  wr_timer <= wr_timer - WT_W'(1);
      if (pre_new)              pre_busy <= 1'b1;
      else if (pre_fin)         pre_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/rank_wake_timer.sv
module rank_wake_timer #(
  parameter int TW  = 16,
  parameter int TXP = 3,
  parameter int TXS = 10,
  parameter int TCK = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_ev,
  input  logic          wake_req,
  input  logic          in_lp,
  input  logic          from_sref,
  output logic          wake_fire,
  output logic [TW-1:0] earliest_cmd
);

  logic [TW-1:0] now;
  logic [TW-1:0] wake_ok_at;
  logic [TW-1:0] exit_dly;
  logic          wake_pend;

  function automatic logic [TW-1:0] later_of(logic [TW-1:0] a, logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign exit_dly  = from_sref ? TW'(TXS) : TW'(TXP);
  assign wake_fire = in_lp && (wake_req || wake_pend) && (now >= wake_ok_at);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now          <= '0;
      wake_ok_at   <= '0;
      wake_pend    <= 1'b0;
      earliest_cmd <= '0;
    end else begin
      now <= now + TW'(1);
      if (enter_ev) wake_ok_at <= now + TW'(TCK);
      if (enter_ev || wake_fire) wake_pend <= 1'b0;
      else if (wake_req)         wake_pend <= 1'b1;
      if (wake_fire) earliest_cmd <= later_of(earliest_cmd, now + exit_dly);
    end
  end

endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_cnt,
  input  logic              rd_resp,
  input  logic              pre_done,
  input  logic              access_req,
  input  logic              sref_req,
  input  logic              sref_exit,
  input  logic              ready_next,
  input  logic              wake_fire,
  output pwr_state_e        state,
  output logic              in_lp,
  output logic              from_sref,
  output logic              wake_req,
  output logic              enter_ev,
  output logic              enter_act_pd,
  output logic              enter_pre_pd,
  output logic              enter_sref,
  output logic              exit_act_pd,
  output logic              exit_pre_pd,
  output logic              exit_sref
);

  pwr_state_e nxt;
  logic n_eact, n_epre, n_esr, n_xact, n_xpre, n_xsr;
  logic awake_ok;

  assign in_lp     = is_low_power(state);
  assign from_sref = (state == PS_SELFREF);
  assign awake_ok  = (state == PS_ACTIVE) || (state == PS_IDLE);
  assign wake_req  = (access_req && ((state == PS_PRE_DOWN) || (state == PS_ACT_DOWN)))
                   || (sref_exit && (state == PS_SELFREF));
  assign enter_ev  = n_eact || n_epre || n_esr;

  always_comb begin
    nxt    = state;
    n_eact = 1'b0;
    n_epre = 1'b0;
    n_esr  = 1'b0;
    n_xact = 1'b0;
    n_xpre = 1'b0;
    n_xsr  = 1'b0;
    if (wake_fire) begin
      unique case (state)
        PS_ACT_DOWN: begin nxt = PS_ACTIVE; n_xact = 1'b1; end
        PS_PRE_DOWN: begin nxt = PS_IDLE;   n_xpre = 1'b1; end
        PS_SELFREF:  begin nxt = PS_IDLE;   n_xsr  = 1'b1; end
        default:     nxt = state;
      endcase
    end else if (awake_ok) begin
      if (pre_done && (bank_cnt == '0)) begin
        if (ready_next) begin nxt = PS_PRE_DOWN; n_epre = 1'b1; end
        else            nxt = PS_IDLE;
      end else if (rd_resp && ready_next) begin
        if (state == PS_ACTIVE) begin nxt = PS_ACT_DOWN; n_eact = 1'b1; end
        else                    begin nxt = PS_PRE_DOWN; n_epre = 1'b1; end
      end else if (sref_req && (state == PS_IDLE) && ready_next) begin
        nxt   = PS_SELFREF;
        n_esr = 1'b1;
      end else if ((state == PS_IDLE) && (bank_cnt != '0)) begin
        nxt = PS_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= PS_IDLE;
      enter_act_pd <= 1'b0;
      enter_pre_pd <= 1'b0;
      enter_sref   <= 1'b0;
      exit_act_pd  <= 1'b0;
      exit_pre_pd  <= 1'b0;
      exit_sref    <= 1'b0;
    end else begin
      state        <= nxt;
      enter_act_pd <= n_eact;
      enter_pre_pd <= n_epre;
      enter_sref   <= n_esr;
      exit_act_pd  <= n_xact;
      exit_pre_pd  <= n_xpre;
      exit_sref    <= n_xsr;
    end
  end

endmodule

// File: rtl/rank_sleep_ctrl.sv
module rank_sleep_ctrl
  import rank_pwr_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int TW     = 16,
  parameter int BANK_W = 4,
  parameter int TXP    = 3,
  parameter int TXS    = 10,
  parameter int TCK    = 2,
  parameter int WR_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_is_write,
  input  logic              ref_running,
  input  logic [BANK_W-1:0] bank_cnt,
  input  logic              rd_enq,
  input  logic              rd_issue,
  input  logic              rd_resp,
  input  logic              wr_enq,
  input  logic              wr_issue,
  input  logic              pre_start,
  input  logic              pre_done,
  input  logic              access_req,
  input  logic              sref_req,
  input  logic              sref_exit,
  output logic [2:0]        pwr_state,
  output logic              enter_act_pd,
  output logic              enter_pre_pd,
  output logic              enter_sref,
  output logic              exit_act_pd,
  output logic              exit_pre_pd,
  output logic              exit_sref,
  output logic [TW-1:0]     earliest_cmd,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic [CNT_W-1:0]  op_cnt
);

  logic [CNT_W-1:0] rd_next, wr_next, op_next;
  logic             wr_done_ev;
  logic             ready_next;
  logic             wake_fire;
  logic             wake_req;
  logic             enter_ev;
  logic             in_lp;
  logic             from_sref;
  pwr_state_e       state;

  rank_op_counters #(.CNT_W(CNT_W), .WR_LAT(WR_LAT)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .rd_enq(rd_enq), .rd_issue(rd_issue), .rd_resp(rd_resp),
    .wr_enq(wr_enq), .wr_issue(wr_issue),
    .pre_start(pre_start), .pre_done(pre_done),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .op_cnt(op_cnt),
    .rd_next(rd_next), .wr_next(wr_next), .op_next(op_next),
    .wr_done_ev(wr_done_ev)
  );

  // queue for the active direction drained, and nothing in flight unless refreshing
  assign ready_next = (bus_is_write ? (wr_next == '0) : (rd_next == '0))
                    && (ref_running || (op_next == '0));

  rank_pwr_fsm #(.BANK_W(BANK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bank_cnt(bank_cnt),
    .rd_resp(rd_resp), .pre_done(pre_done), .access_req(access_req),
    .sref_req(sref_req), .sref_exit(sref_exit),
    .ready_next(ready_next), .wake_fire(wake_fire),
    .state(state), .in_lp(in_lp), .from_sref(from_sref),
    .wake_req(wake_req), .enter_ev(enter_ev),
    .enter_act_pd(enter_act_pd), .enter_pre_pd(enter_pre_pd), .enter_sref(enter_sref),
    .exit_act_pd(exit_act_pd), .exit_pre_pd(exit_pre_pd), .exit_sref(exit_sref)
  );

  rank_wake_timer #(.TW(TW), .TXP(TXP), .TXS(TXS), .TCK(TCK)) u_wake (
    .clk(clk), .rst_n(rst_n), .enter_ev(enter_ev), .wake_req(wake_req),
    .in_lp(in_lp), .from_sref(from_sref),
    .wake_fire(wake_fire), .earliest_cmd(earliest_cmd)
  );

  assign pwr_state = state;

endmodule

// File: rtl/rank_sleep_ctrl_chk.sv
module rank_sleep_ctrl_chk
  import rank_pwr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TW    = 16,
  parameter int TCK   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       pwr_state,
  input logic             enter_act_pd,
  input logic             enter_pre_pd,
  input logic             enter_sref,
  input logic             exit_act_pd,
  input logic             exit_pre_pd,
  input logic             exit_sref,
  input logic [TW-1:0]    earliest_cmd,
  input logic [CNT_W-1:0] rd_cnt,
  input logic             rd_enq,
  input logic             rd_resp,
  input logic             sref_exit,
  input logic             wake_fire,
  input logic             enter_ev
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  // R11
  earliest_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> earliest_cmd >= $past(earliest_cmd));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_act_pd, enter_pre_pd, enter_sref, exit_act_pd, exit_pre_pd, exit_sref}));

  // R9
  act_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_act_pd) |-> (pwr_state == PS_ACTIVE) && ($past(pwr_state) == PS_ACT_DOWN));

  // R10
  sref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == PS_SELFREF) && !sref_exit && !wake_fire |=> pwr_state == PS_SELFREF);

  // R2
  rd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == '0) && !rd_enq |=> rd_cnt == '0);

  // R2
  rd_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt == CMAX) && !rd_resp |=> rd_cnt == CMAX);

  generate
    if (TCK >= 2) begin : g_gap
      // R8
      wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_ev |=> !wake_fire);
    end
  endgenerate

endmodule

bind rank_sleep_ctrl rank_sleep_ctrl_chk #(.CNT_W(CNT_W), .TW(TW), .TCK(TCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
  .enter_act_pd(enter_act_pd), .enter_pre_pd(enter_pre_pd), .enter_sref(enter_sref),
  .exit_act_pd(exit_act_pd), .exit_pre_pd(exit_pre_pd), .exit_sref(exit_sref),
  .earliest_cmd(earliest_cmd), .rd_cnt(rd_cnt), .rd_enq(rd_enq), .rd_resp(rd_resp),
  .sref_exit(sref_exit), .wake_fire(wake_fire), .enter_ev(enter_ev)
);

// File: tb/test_rank_sleep_ctrl.sv
`timescale 1ns/1ps
module test_rank_sleep_ctrl;

  localparam int CNT_W = 4, TW = 16, BANK_W = 4, TXP = 3, TXS = 10, TCK = 2, WR_LAT = 4;
  // state codes (R1)
  localparam int S_IDLE = 0, S_SREF = 2, S_PPD = 3, S_ACT = 4, S_APD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_is_write = 0, ref_running = 0;
  logic [BANK_W-1:0] bank_cnt = '0;
  logic rd_enq = 0, rd_issue = 0, rd_resp = 0, wr_enq = 0, wr_issue = 0;
  logic pre_start = 0, pre_done = 0, access_req = 0, sref_req = 0, sref_exit = 0;
  logic [2:0] pwr_state;
  logic enter_act_pd, enter_pre_pd, enter_sref, exit_act_pd, exit_pre_pd, exit_sref;
  logic [TW-1:0] earliest_cmd;
  logic [CNT_W-1:0] rd_cnt, wr_cnt, op_cnt;

  int checks = 0, errors = 0, cyc = 0, exp_early = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rank_sleep_ctrl #(.CNT_W(CNT_W), .TW(TW), .BANK_W(BANK_W), .TXP(TXP), .TXS(TXS),
                    .TCK(TCK), .WR_LAT(WR_LAT)) i_rank_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_is_write(bus_is_write), .ref_running(ref_running),
    .bank_cnt(bank_cnt), .rd_enq(rd_enq), .rd_issue(rd_issue), .rd_resp(rd_resp),
    .wr_enq(wr_enq), .wr_issue(wr_issue), .pre_start(pre_start), .pre_done(pre_done),
    .access_req(access_req), .sref_req(sref_req), .sref_exit(sref_exit),
    .pwr_state(pwr_state), .enter_act_pd(enter_act_pd), .enter_pre_pd(enter_pre_pd),
    .enter_sref(enter_sref), .exit_act_pd(exit_act_pd), .exit_pre_pd(exit_pre_pd),
    .exit_sref(exit_sref), .earliest_cmd(earliest_cmd),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .op_cnt(op_cnt)
  );

  // input bits: 11 bus_w,10 ref,9 rd_enq,8 rd_issue,7 rd_resp,6 wr_enq,5 wr_issue,
  // 4 pre_start,3 pre_done,2 access,1 sref_req,0 sref_exit
  // row: {inputs[12], bank[4], exp_state[3], exp_rd[4], exp_op[4], exp_strobe[3]}
  // strobe code: 0 none,1 enter act,2 enter pre,3 enter sref,4 exit act,5 exit pre,6 exit sref
  localparam int NV = 16;
  localparam logic [29:0] VEC [NV] = '{
    {12'b0010_0000_0000, 4'd1, 3'd4, 4'd1, 4'd0, 3'd0},
    {12'b0001_0000_0000, 4'd1, 3'd4, 4'd1, 4'd1, 3'd0},
    {12'b0010_0000_0000, 4'd1, 3'd4, 4'd2, 4'd1, 3'd0},
    {12'b0000_1000_0000, 4'd1, 3'd4, 4'd1, 4'd0, 3'd0},
    {12'b0001_0000_0000, 4'd1, 3'd4, 4'd1, 4'd1, 3'd0},
    {12'b0000_1000_0000, 4'd1, 3'd5, 4'd0, 4'd0, 3'd1},
    {12'b0000_0000_0100, 4'd1, 3'd5, 4'd0, 4'd0, 3'd0},
    {12'b0000_0000_0000, 4'd1, 3'd4, 4'd0, 4'd0, 3'd4},
    {12'b0000_0001_0000, 4'd1, 3'd4, 4'd0, 4'd1, 3'd0},
    {12'b0000_0000_1000, 4'd0, 3'd3, 4'd0, 4'd0, 3'd2},
    {12'b0000_0000_0100, 4'd0, 3'd3, 4'd0, 4'd0, 3'd0},
    {12'b0000_0000_0000, 4'd0, 3'd0, 4'd0, 4'd0, 3'd5},
    {12'b0000_0000_0010, 4'd0, 3'd2, 4'd0, 4'd0, 3'd3},
    {12'b0000_0000_0100, 4'd0, 3'd2, 4'd0, 4'd0, 3'd0},
    {12'b0000_0000_0000, 4'd0, 3'd2, 4'd0, 4'd0, 3'd0},
    {12'b0000_0000_0001, 4'd0, 3'd0, 4'd0, 4'd0, 3'd6}
  };

  function automatic int strobe_code();
    if (enter_act_pd) return 1;
    if (enter_pre_pd) return 2;
    if (enter_sref)   return 3;
    if (exit_act_pd)  return 4;
    if (exit_pre_pd)  return 5;
    if (exit_sref)    return 6;
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_in(logic [11:0] v);
    {bus_is_write, ref_running, rd_enq, rd_issue, rd_resp, wr_enq, wr_issue,
     pre_start, pre_done, access_req, sref_req, sref_exit} = v;
  endtask

  // one edge; returns the cycle number sampled at that edge
  task automatic step(output int t);
    t = cyc;
    @(posedge clk);
    #1;
    cyc++;
  endtask

  task automatic wake_seen(int t, int dly);
    if (t + dly > exp_early) exp_early = t + dly;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int t;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc = 0;

    // R1 reset state
    chk("R1", "state", int'(pwr_state), S_IDLE);
    chk("R1", "rd_cnt", int'(rd_cnt), 0);
    chk("R1", "op_cnt", int'(op_cnt), 0);
    chk("R1", "earliest", int'(earliest_cmd), 0);
    chk("R1", "strobes", strobe_code(), 0);

    // table walk: R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][29:18]);
      bank_cnt = VEC[i][17:14];
      step(t);
      if (VEC[i][2:0] == 3'd4 || VEC[i][2:0] == 3'd5) wake_seen(t, TXP);
      if (VEC[i][2:0] == 3'd6) wake_seen(t, TXS);
      chk("R5-row", $sformatf("state row %0d", i), int'(pwr_state), int'(VEC[i][13:11]));
      chk("R2", $sformatf("rd_cnt row %0d", i), int'(rd_cnt), int'(VEC[i][10:7]));
      chk("R3", $sformatf("op_cnt row %0d", i), int'(op_cnt), int'(VEC[i][6:3]));
      chk("R9", $sformatf("strobe row %0d", i), strobe_code(), int'(VEC[i][2:0]));
      chk("R11", $sformatf("earliest row %0d", i), int'(earliest_cmd), exp_early);
    end
    set_in('0);

    // R7 bank opened in IDLE
    bank_cnt = 4'd1;
    step(t);
    chk("R7", "idle to act", int'(pwr_state), S_ACT);
    rd_enq = 1; step(t); rd_enq = 0;
    rd_issue = 1; step(t); rd_issue = 0;
    // R4 last response with a same-cycle enqueue: no entry
    rd_enq = 1; rd_resp = 1; step(t); rd_enq = 0; rd_resp = 0;
    chk("R4", "same-cycle enq state", int'(pwr_state), S_ACT);
    chk("R4", "same-cycle enq strobe", strobe_code(), 0);
    chk("R4", "same-cycle rd_cnt", int'(rd_cnt), 1);
    chk("R4", "same-cycle op_cnt", int'(op_cnt), 0);
    // R4 write direction ignores queued reads
    rd_enq = 1; step(t); rd_enq = 0;
    rd_issue = 1; step(t); rd_issue = 0;
    bus_is_write = 1; rd_resp = 1; step(t); rd_resp = 0;
    chk("R4", "write mode entry", int'(pwr_state), S_APD);
    chk("R5", "enter act strobe", strobe_code(), 1);
    // R8 request right after entry is deferred
    access_req = 1; step(t); access_req = 0;
    chk("R8", "deferred wake", int'(pwr_state), S_APD);
    step(t);
    wake_seen(t, TXP);
    chk("R8", "late wake", int'(pwr_state), S_ACT);
    chk("R9", "earliest after wake", int'(earliest_cmd), exp_early);
    bus_is_write = 0;

    // R3 write-done window extended by a second write
    wr_enq = 1; step(t); wr_enq = 0;
    wr_issue = 1; step(t); wr_issue = 0;
    chk("R3", "write op_cnt", int'(op_cnt), 1);
    chk("R2", "wr_cnt after issue", int'(wr_cnt), 0);
    step(t); step(t);
    wr_issue = 1; step(t); wr_issue = 0;
    chk("R2", "wr_cnt no underflow", int'(wr_cnt), 0);
    chk("R3", "extended op_cnt", int'(op_cnt), 1);
    step(t); step(t); step(t);
    chk("R3", "window still open", int'(op_cnt), 1);
    step(t);
    chk("R3", "window closed", int'(op_cnt), 0);

    // R4 refresh ignores in-flight count (rd_cnt = 1 here)
    rd_issue = 1; step(t); step(t); rd_issue = 0;
    rd_resp = 1; step(t); rd_resp = 0;
    chk("R4", "in-flight blocks entry", int'(pwr_state), S_ACT);
    chk("R4", "in-flight op_cnt", int'(op_cnt), 1);
    rd_enq = 1; step(t); rd_enq = 0;
    rd_issue = 1; step(t); rd_issue = 0;
    ref_running = 1; rd_resp = 1; step(t); rd_resp = 0; ref_running = 0;
    chk("R4", "refresh entry", int'(pwr_state), S_APD);

    // R9 wake long after entry is immediate
    step(t); step(t); step(t);
    access_req = 1; step(t); access_req = 0;
    wake_seen(t, TXP);
    chk("R9", "immediate wake", int'(pwr_state), S_ACT);
    chk("R9", "exit act strobe", strobe_code(), 4);
    chk("R11", "earliest monotonic", int'(earliest_cmd), exp_early);

    // R2 saturation
    rd_enq = 1;
    repeat (18) step(t);
    rd_enq = 0;
    chk("R2", "rd saturates", int'(rd_cnt), (1 << CNT_W) - 1);

    summary();
  end

endmodule